// File: doc/BRIEF.md
# Background/Object Pixel Mixer

This block sits at the end of a tile-based display pipeline. On every dot it receives the head pixel from the background queue and the head pixel from the object queue. It decides which of the two is shown and converts the chosen colour index into a display value. It then drives that value to the panel as a registered pixel with a one-cycle valid strobe.

Two display modes are supported. In monochrome mode the index selects a 2-bit shade from one of three 8-bit shade registers. In colour mode the index selects a 15-bit RGB entry from an internal palette RAM, which holds a background set and an object set of palettes and is loaded through a simple write port. A palette-blocked input forces the colour output to black.

The selection follows an ordered rule chain. Some rules apply only in colour mode and some only in monochrome mode. The queues, the tile fetch logic and the panel timing are outside this block.

Top module: `pix_mixer`

## Requirements
- R1: The outputs are registered: the result for the inputs present at one rising edge appears after that edge. `pix_valid` is 1 exactly when, at that edge, `bg_valid` was 1 and `hpos` was below 160 (`LINE_W`).
- R2: In colour mode (`color_mode`=1), when `bg_enable` is 0, the background pixel is shown regardless of the object pixel.
- R3: In monochrome mode, when `bg_enable` is 0, the background colour is taken as index 0 for every later rule and for the shade lookup, so a non-zero object pixel wins even when its priority bit is set.
- R4: When `obj_enable` is 0, the background pixel is shown.
- R5: In colour mode, a background pixel with `bg_prio`=1 and a non-zero colour is shown over the object pixel.
- R6: An object pixel with `obj_prio`=1 gives way to a background pixel whose colour is non-zero. If the background colour is 0, the object pixel is shown.
- R7: When no earlier rule decides, the object pixel is shown unless its colour index is 0 (transparent), in which case the background pixel is shown.
- R8: In monochrome mode, background pixels use `mono_bg_pal`. Object pixels use `mono_obj_pal0` when `obj_pal[0]`=0 and `mono_obj_pal1` when `obj_pal[0]`=1. Index i selects bits [2i+1:2i] of the register.
- R9: In colour mode the shown pixel's palette number and index select an RGB entry from the background set or the object set, according to which pixel won. A write with `cram_we`=1 stores `cram_wdata` at palette `cram_addr[4:2]`, colour `cram_addr[1:0]`. The write goes to the object set when `cram_is_obj`=1 and to the background set otherwise, and it leaves the other set unchanged.
- R10: In colour mode, while `pal_blocked`=1, a shown pixel has `pix_rgb`=0 (black). In monochrome mode `pal_blocked` has no effect on the shade.
- R11: After reset all outputs are 0. `pix_rgb` is 0 in monochrome mode, `pix_shade` is 0 in colour mode, and both are 0 when `pix_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bg_valid | input | 1 | Background queue has a head pixel |
| bg_color | input | 2 | Background colour index |
| bg_pal | input | 3 | Background palette number (colour mode) |
| bg_prio | input | 1 | Background-over-object bit (colour mode) |
| obj_color | input | 2 | Object colour index, 0 = transparent |
| obj_pal | input | 3 | Object palette number; bit 0 selects the shade register in monochrome mode |
| obj_prio | input | 1 | Object-behind-background bit |
| hpos | input | 8 | Horizontal position of the pixel |
| color_mode | input | 1 | 1 = colour mode, 0 = monochrome mode |
| bg_enable | input | 1 | Background enable / master priority bit |
| obj_enable | input | 1 | Object display enable |
| pal_blocked | input | 1 | Palette read blocked (forces black in colour mode) |
| mono_bg_pal | input | 8 | Background shade register |
| mono_obj_pal0 | input | 8 | Object shade register 0 |
| mono_obj_pal1 | input | 8 | Object shade register 1 |
| cram_we | input | 1 | Palette RAM write enable |
| cram_is_obj | input | 1 | Write target set: 1 = object, 0 = background |
| cram_addr | input | 5 | Palette RAM address {palette, colour} |
| cram_wdata | input | 15 | RGB entry to store |
| pix_valid | output | 1 | One-cycle strobe per shown pixel |
| pix_rgb | output | 15 | Colour-mode pixel value |
| pix_shade | output | 2 | Monochrome-mode shade |

## Verification
The bench builds the block with its default parameters: eight palettes per set and a 160-pixel line held in an 8-bit position. With these values the line-end boundary at positions 159 and 160 can be reached directly, and so can every palette number that the 3-bit fields carry. Shade registers with asymmetric patterns make each index and register choice visible at the output. Palette entries written at distinct addresses in both sets show whether the wrong set or the wrong entry was read.

// File: rtl/pix_mixer_pkg.sv
package pix_mixer_pkg;

    localparam int RGB_W   = 15;
    localparam int IDX_W   = 2;
    localparam int SHADE_W = 2;

    typedef enum logic {
        SRC_BG  = 1'b0,
        SRC_OBJ = 1'b1
    } pix_src_e;

    typedef struct packed {
        logic               valid;
        logic [RGB_W-1:0]   rgb;
        logic [SHADE_W-1:0] shade;
    } pix_out_s;

endpackage

// File: rtl/pix_prio_sel.sv
module pix_prio_sel
    import pix_mixer_pkg::*;
(
    input  logic             color_mode,
    input  logic             bg_enable,
    input  logic             obj_enable,
    input  logic [IDX_W-1:0] bg_color,
    input  logic             bg_prio,
    input  logic [IDX_W-1:0] obj_color,
    input  logic             obj_prio,
    output pix_src_e         src,
    output logic [IDX_W-1:0] bg_color_eff
);

    logic bg_opaque;

    always_comb begin
        // in monochrome mode a disabled background reads as index 0
        bg_color_eff = (!color_mode && !bg_enable) ? '0 : bg_color;
        bg_opaque    = (bg_color_eff != '0);

        if (color_mode && !bg_enable)
            src = SRC_BG;
        else if (!obj_enable)
            src = SRC_BG;
        else if (color_mode && bg_prio && bg_opaque)
            src = SRC_BG;
        else if (obj_prio && bg_opaque)
            src = SRC_BG;
        else if (obj_color == '0)
            src = SRC_BG;
        else
            src = SRC_OBJ;
    end

endmodule

// File: rtl/pix_shade_lut.sv
module pix_shade_lut
    import pix_mixer_pkg::*;
#(
    parameter  int ENTRIES = 4,
    localparam int REG_W   = ENTRIES * SHADE_W
) (
    input  logic [REG_W-1:0]   shade_reg,
    input  logic [IDX_W-1:0]   idx,
    output logic [SHADE_W-1:0] shade
);

    always_comb begin
        shade = shade_reg[SHADE_W*idx +: SHADE_W];
    end

endmodule

// File: rtl/pix_cram.sv
module pix_cram
    import pix_mixer_pkg::*;
#(
    parameter  int NUM_PAL = 8,
    localparam int PAL_W   = $clog2(NUM_PAL),
    localparam int ADDR_W  = PAL_W + IDX_W,
    localparam int DEPTH   = NUM_PAL << IDX_W,
    localparam int NUM_SET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              we_is_obj,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [RGB_W-1:0]  wdata,
    input  pix_src_e          rd_set,
    input  logic [PAL_W-1:0]  rd_pal,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [RGB_W-1:0]  rd_rgb
);

    logic [ADDR_W-1:0] raddr;
    logic [RGB_W-1:0]  set_rd [NUM_SET];

    assign raddr = {rd_pal, rd_idx};

    for (genvar g = 0; g < NUM_SET; g++) begin : g_set
        logic [RGB_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (we && (we_is_obj == (g == 1))) begin
                mem_q[waddr] <= wdata;
            end
        end

        assign set_rd[g] = mem_q[raddr];
    end

    assign rd_rgb = (rd_set == SRC_OBJ) ? set_rd[1] : set_rd[0];

endmodule

// File: rtl/pix_mixer.sv
module pix_mixer
    import pix_mixer_pkg::*;
#(
    parameter  int NUM_PAL = 8,
    parameter  int LINE_W  = 160,
    parameter  int HPOS_W  = 8,
    localparam int PAL_W   = $clog2(NUM_PAL),
    localparam int ADDR_W  = PAL_W + IDX_W,
    localparam int SREG_W  = (1 << IDX_W) * SHADE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bg_valid,
    input  logic [IDX_W-1:0]    bg_color,
    input  logic [PAL_W-1:0]    bg_pal,
    input  logic                bg_prio,
    input  logic [IDX_W-1:0]    obj_color,
    input  logic [PAL_W-1:0]    obj_pal,
    input  logic                obj_prio,
    input  logic [HPOS_W-1:0]   hpos,
    input  logic                color_mode,
    input  logic                bg_enable,
    input  logic                obj_enable,
    input  logic                pal_blocked,
    input  logic [SREG_W-1:0]   mono_bg_pal,
    input  logic [SREG_W-1:0]   mono_obj_pal0,
    input  logic [SREG_W-1:0]   mono_obj_pal1,
    input  logic                cram_we,
    input  logic                cram_is_obj,
    input  logic [ADDR_W-1:0]   cram_addr,
    input  logic [RGB_W-1:0]    cram_wdata,
    output logic                pix_valid,
    output logic [RGB_W-1:0]    pix_rgb,
    output logic [SHADE_W-1:0]  pix_shade
);

    pix_src_e           src;
    logic [IDX_W-1:0]   bg_color_eff;
    logic [SREG_W-1:0]  sreg_sel;
    logic [IDX_W-1:0]   mono_idx;
    logic [SHADE_W-1:0] mono_shade;
    logic [PAL_W-1:0]   cram_pal;
    logic [IDX_W-1:0]   cram_idx;
    logic [RGB_W-1:0]   cram_rgb;
    logic               shown;
    pix_out_s           out_d, out_q;

    pix_prio_sel u_prio (
        .color_mode   (color_mode),
        .bg_enable    (bg_enable),
        .obj_enable   (obj_enable),
        .bg_color     (bg_color),
        .bg_prio      (bg_prio),
        .obj_color    (obj_color),
        .obj_prio     (obj_prio),
        .src          (src),
        .bg_color_eff (bg_color_eff)
    );

    always_comb begin
        if (src == SRC_BG)
            sreg_sel = mono_bg_pal;
        else
            sreg_sel = obj_pal[0] ? mono_obj_pal1 : mono_obj_pal0;
        mono_idx = (src == SRC_BG) ? bg_color_eff : obj_color;
        cram_pal = (src == SRC_BG) ? bg_pal : obj_pal;
        cram_idx = (src == SRC_BG) ? bg_color : obj_color;
    end

    pix_shade_lut #(.ENTRIES(1 << IDX_W)) u_shade (
        .shade_reg (sreg_sel),
        .idx       (mono_idx),
        .shade     (mono_shade)
    );

    pix_cram #(.NUM_PAL(NUM_PAL)) u_cram (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cram_we),
        .we_is_obj (cram_is_obj),
        .waddr     (cram_addr),
        .wdata     (cram_wdata),
        .rd_set    (src),
        .rd_pal    (cram_pal),
        .rd_idx    (cram_idx),
        .rd_rgb    (cram_rgb)
    );

    always_comb begin
        shown        = bg_valid && (32'(hpos) < LINE_W);
        out_d        = '0;
        out_d.valid  = shown;
        if (shown) begin
            if (color_mode)
                out_d.rgb = pal_blocked ? '0 : cram_rgb;
            else
                out_d.shade = mono_shade;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pix_valid = out_q.valid;
    assign pix_rgb   = out_q.rgb;
    assign pix_shade = out_q.shade;

endmodule

// File: rtl/pix_mixer_chk.sv
module pix_mixer_chk
    import pix_mixer_pkg::*;
#(
    parameter int LINE_W = 160,
    parameter int HPOS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bg_valid,
    input logic [IDX_W-1:0]   bg_color,
    input logic [HPOS_W-1:0]  hpos,
    input logic               color_mode,
    input logic               bg_enable,
    input logic               obj_enable,
    input logic               pal_blocked,
    input logic [7:0]         mono_bg_pal,
    input logic               pix_valid,
    input logic [RGB_W-1:0]   pix_rgb,
    input logic [SHADE_W-1:0] pix_shade
);

    logic on_line;
    assign on_line = bg_valid && (32'(hpos) < LINE_W);

    a_r1_valid_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        on_line |=> pix_valid);

    a_r1_quiet_off_line: assert property (@(posedge clk) disable iff (!rst_n)
        !on_line |=> !pix_valid);

    a_r10_black_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (color_mode && pal_blocked) |=> (pix_rgb == '0));

    a_r11_rgb_idle_mono: assert property (@(posedge clk) disable iff (!rst_n)
        !color_mode |=> (pix_rgb == '0));

    a_r11_shade_idle_color: assert property (@(posedge clk) disable iff (!rst_n)
        color_mode |=> (pix_shade == '0));

    a_r11_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_rgb == '0 && pix_shade == '0));

    a_r4_obj_off_uses_bg: assert property (@(posedge clk) disable iff (!rst_n)
        (!color_mode && !obj_enable && bg_enable && on_line)
        |=> (pix_shade == 2'($past(mono_bg_pal) >> (2 * $past(bg_color)))));

endmodule

bind pix_mixer pix_mixer_chk #(.LINE_W(LINE_W), .HPOS_W(HPOS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bg_valid    (bg_valid),
    .bg_color    (bg_color),
    .hpos        (hpos),
    .color_mode  (color_mode),
    .bg_enable   (bg_enable),
    .obj_enable  (obj_enable),
    .pal_blocked (pal_blocked),
    .mono_bg_pal (mono_bg_pal),
    .pix_valid   (pix_valid),
    .pix_rgb     (pix_rgb),
    .pix_shade   (pix_shade)
);

// File: tb/tb_pix_mixer.sv
module tb_pix_mixer;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bg_valid = 1'b0;
    logic [1:0]  bg_color = '0;
    logic [2:0]  bg_pal = '0;
    logic        bg_prio = 1'b0;
    logic [1:0]  obj_color = '0;
    logic [2:0]  obj_pal = '0;
    logic        obj_prio = 1'b0;
    logic [7:0]  hpos = '0;
    logic        color_mode = 1'b0;
    logic        bg_enable = 1'b1;
    logic        obj_enable = 1'b1;
    logic        pal_blocked = 1'b0;
    logic [7:0]  mono_bg_pal = 8'hE4;
    logic [7:0]  mono_obj_pal0 = 8'h1B;
    logic [7:0]  mono_obj_pal1 = 8'h93;
    logic        cram_we = 1'b0;
    logic        cram_is_obj = 1'b0;
    logic [4:0]  cram_addr = '0;
    logic [14:0] cram_wdata = '0;
    logic        pix_valid;
    logic [14:0] pix_rgb;
    logic [1:0]  pix_shade;

    int checks = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pix_mixer dut (.*);

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic set_pix(input logic [1:0] bc, input logic [2:0] bp, input logic bpr,
                           input logic [1:0] oc, input logic [2:0] op, input logic opr);
        bg_valid = 1'b1; hpos = 8'd10;
        bg_color = bc; bg_pal = bp; bg_prio = bpr;
        obj_color = oc; obj_pal = op; obj_prio = opr;
    endtask

    // inputs set at negedge, registered at posedge, checked at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cram_write(input logic is_obj, input logic [2:0] pal,
                              input logic [1:0] idx, input logic [14:0] val);
        cram_we = 1'b1; cram_is_obj = is_obj; cram_addr = {pal, idx}; cram_wdata = val;
        step();
        cram_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "reset valid", int'(pix_valid), 0);
        chk("R11", "reset rgb", int'(pix_rgb), 0);
        chk("R11", "reset shade", int'(pix_shade), 0);
    endtask

    task automatic t_mono_basic();
        color_mode = 1'b0; bg_enable = 1'b1; obj_enable = 1'b1; mono_bg_pal = 8'hE4;
        set_pix(2'd1, 3'd0, 1'b0, 2'd2, 3'd0, 1'b0); step();
        chk("R7", "opaque obj wins", int'(pix_shade), 1);
        chk("R8", "obj pal0 index 2", int'(pix_shade), 1);
        chk("R11", "rgb zero in mono", int'(pix_rgb), 0);
        set_pix(2'd2, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0); step();
        chk("R7", "transparent obj shows bg", int'(pix_shade), 2);
        set_pix(2'd3, 3'd0, 1'b0, 2'd3, 3'd1, 1'b1); step();
        chk("R6", "obj behind opaque bg", int'(pix_shade), 3);
        set_pix(2'd0, 3'd0, 1'b0, 2'd3, 3'd1, 1'b1); step();
        chk("R6", "obj behind clear bg shows obj", int'(pix_shade), 2);
        set_pix(2'd0, 3'd0, 1'b0, 2'd1, 3'd1, 1'b0); step();
        chk("R8", "obj pal1 index 1", int'(pix_shade), 0);
        set_pix(2'd0, 3'd0, 1'b0, 2'd0, 3'd1, 1'b0); step();
        chk("R8", "bg index 0 of E4", int'(pix_shade), 0);
    endtask

    task automatic t_mono_bg_off();
        color_mode = 1'b0; bg_enable = 1'b0; mono_bg_pal = 8'h1B;
        set_pix(2'd3, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0); step();
        chk("R3", "disabled bg reads index 0", int'(pix_shade), 3);
        set_pix(2'd3, 3'd0, 1'b0, 2'd2, 3'd0, 1'b1); step();
        chk("R3", "prio obj over disabled bg", int'(pix_shade), 1);
        bg_enable = 1'b1; mono_bg_pal = 8'hE4;
    endtask

    task automatic t_obj_off();
        color_mode = 1'b0; obj_enable = 1'b0;
        set_pix(2'd1, 3'd0, 1'b0, 2'd3, 3'd0, 1'b0); step();
        chk("R4", "mono obj disabled", int'(pix_shade), 1);
        color_mode = 1'b1;
        set_pix(2'd2, 3'd5, 1'b0, 2'd1, 3'd3, 1'b0); step();
        chk("R4", "color obj disabled", int'(pix_rgb), 'h1234);
        obj_enable = 1'b1;
    endtask

    task automatic t_color();
        color_mode = 1'b1; bg_enable = 1'b1; obj_enable = 1'b1;
        set_pix(2'd0, 3'd5, 1'b0, 2'd1, 3'd3, 1'b0); step();
        chk("R9", "obj set pal3 idx1", int'(pix_rgb), 'h7C00);
        chk("R11", "shade zero in color", int'(pix_shade), 0);
        set_pix(2'd0, 3'd5, 1'b0, 2'd0, 3'd3, 1'b0); step();
        chk("R9", "bg set pal5 idx0", int'(pix_rgb), 'h0101);
        bg_enable = 1'b0;
        set_pix(2'd2, 3'd5, 1'b0, 2'd1, 3'd3, 1'b0); step();
        chk("R2", "master priority off shows bg", int'(pix_rgb), 'h1234);
        bg_enable = 1'b1;
        set_pix(2'd2, 3'd5, 1'b1, 2'd1, 3'd3, 1'b0); step();
        chk("R5", "bg prio opaque wins", int'(pix_rgb), 'h1234);
        set_pix(2'd0, 3'd5, 1'b1, 2'd3, 3'd6, 1'b0); step();
        chk("R5", "bg prio clear loses", int'(pix_rgb), 'h03E0);
        set_pix(2'd2, 3'd5, 1'b0, 2'd1, 3'd3, 1'b1); step();
        chk("R6", "color obj behind opaque bg", int'(pix_rgb), 'h1234);
        set_pix(2'd0, 3'd5, 1'b0, 2'd1, 3'd3, 1'b1); step();
        chk("R6", "color obj over clear bg", int'(pix_rgb), 'h7C00);
    endtask

    task automatic t_sets_separate();
        color_mode = 1'b1;
        cram_write(1'b1, 3'd5, 2'd2, 15'h2AAA);
        set_pix(2'd2, 3'd5, 1'b0, 2'd0, 3'd5, 1'b0); step();
        chk("R9", "bg entry untouched by obj write", int'(pix_rgb), 'h1234);
        set_pix(2'd0, 3'd0, 1'b0, 2'd2, 3'd5, 1'b0); step();
        chk("R9", "obj entry written", int'(pix_rgb), 'h2AAA);
    endtask

    task automatic t_blocked();
        color_mode = 1'b1; pal_blocked = 1'b1;
        set_pix(2'd2, 3'd5, 1'b0, 2'd0, 3'd0, 1'b0); step();
        chk("R10", "blocked gives black", int'(pix_rgb), 0);
        chk("R10", "blocked still valid", int'(pix_valid), 1);
        color_mode = 1'b0;
        set_pix(2'd3, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0); step();
        chk("R10", "mono ignores block", int'(pix_shade), 3);
        pal_blocked = 1'b0;
    endtask

    task automatic t_valid();
        color_mode = 1'b0;
        set_pix(2'd3, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0);
        bg_valid = 1'b0; step();
        chk("R1", "empty bg queue", int'(pix_valid), 0);
        chk("R11", "idle shade zero", int'(pix_shade), 0);
        bg_valid = 1'b1; hpos = 8'd159; step();
        chk("R1", "hpos 159 shown", int'(pix_valid), 1);
        hpos = 8'd160; step();
        chk("R1", "hpos 160 hidden", int'(pix_valid), 0);
        hpos = 8'd255; step();
        chk("R1", "hpos 255 hidden", int'(pix_valid), 0);
        bg_valid = 1'b0; hpos = 8'd0; @(posedge clk); #1;
        chk("R1", "valid is a single pulse", int'(pix_valid), 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        cram_write(1'b0, 3'd5, 2'd2, 15'h1234);
        cram_write(1'b0, 3'd5, 2'd0, 15'h0101);
        cram_write(1'b1, 3'd3, 2'd1, 15'h7C00);
        cram_write(1'b1, 3'd6, 2'd3, 15'h03E0);
        t_mono_basic();
        t_mono_bg_off();
        t_obj_off();
        t_color();
        t_sets_separate();
        t_blocked();
        t_valid();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule